// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the transfer engine of one DMA channel working in single mode. A host-side loader programs a 16-bit start address, a 16-bit count, a mode and an arm action in one strobe. After that, each request from a peripheral moves exactly one unit through a request/acknowledge handshake. For each unit the block puts out a 24-bit physical memory address, built from the channel's current address and an 8-bit page value that is held outside the block. The channel can carry bytes or 16-bit words. In word mode the address counter selects words, so the physical address is the counter shifted left by one. The page value is never changed by the engine, so the address counter wraps inside a 64 KiB window for bytes and a 128 KiB window for words.

The count is programmed as the number of units minus one. The transfer that takes the count from zero to all ones is the last one: it drives a one-cycle terminal-count pulse. At that point the channel either reloads its start address and count from the programmed base values, or masks itself until the next load. In pass-through mode the channel moves no data of its own. It forwards the peripheral request as a hold request and returns the hold acknowledge as its acknowledge.

Top module: `dma_xfer_seq`

## Requirements
- R1: During and after reset, with no load yet, the channel is masked (`masked`=1), and `dack`, `tc` and `hold_req` are 0 even while `dreq` is 1.
- R2: In byte mode (`load_word`=0), the `mem_addr` shown with a transfer's `dack` is {`page`[7:0], current address[15:0]}.
- R3: In word mode (`load_word`=1), `mem_addr` is {`page`[7:1], current address[15:0], 1'b0}, so `page` bit 0 has no effect and `mem_addr` bit 0 is always 0.
- R4: Each transfer adds one to the current address. The address wraps from 0xFFFF to 0x0000, and `mem_addr` bits 23:16 (byte) or 23:17 (word) stay equal to the page input.
- R5: A loaded count L gives exactly L+1 transfers up to and including the terminal one, so a loaded 0 gives one transfer, and that transfer carries `tc`.
- R6: `tc` is high for exactly the one cycle in which `dack` acknowledges the transfer made at count 0. After that transfer without reload, `count_now` reads 0xFFFF.
- R7: A granted request gives `dack` high in the cycle after `dreq` is sampled high, for one cycle only. With `dreq` held high, transfers occur on alternate cycles.
- R8: Without autoinitialize (`load_auto`=0), the terminal transfer sets `masked`. After that, `dreq` gives no `dack` and leaves `count_now` unchanged until the next load.
- R9: With autoinitialize (`load_auto`=1), the terminal transfer reloads the current address and count from the loaded values, and the channel stays unmasked.
- R10: While `masked` is 1, `dack` is never asserted.
- R11: In pass-through mode (`load_cascade`=1, unmasked), `hold_req` follows `dreq` and `dack` follows `hold_ack` in the same cycle, with no registers on the way. `count_now` does not change and `tc` stays 0.
- R12: A `load_stb` cycle sets the current and base address and count, sets the mode, and clears `masked` from the next cycle on. A request in the same cycle as `load_stb` is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_stb | input | 1 | Load the values below and arm the channel |
| load_addr | input | 16 | Start address, in units |
| load_count | input | 16 | Number of units minus one |
| load_word | input | 1 | 1 = word channel, 0 = byte channel |
| load_auto | input | 1 | 1 = reload at terminal count |
| load_cascade | input | 1 | 1 = pass-through mode |
| page | input | 8 | External page value, upper physical address bits |
| dreq | input | 1 | Peripheral request |
| hold_ack | input | 1 | Hold acknowledge from upstream (pass-through) |
| dack | output | 1 | Acknowledge to peripheral |
| hold_req | output | 1 | Hold request upstream (pass-through) |
| tc | output | 1 | Terminal-count pulse |
| mem_addr | output | 24 | Physical address, valid while `dack` is 1 |
| count_now | output | 16 | Current count register |
| masked | output | 1 | Channel mask state |

## Verification
`dack`, `tc` and `mem_addr` are registered, so they are due one rising edge after the edge that samples `dreq`. The address and count registers update on that same edge, so `count_now` and `masked` already show the new state when `dack` rises. The bench drives inputs on falling edges and checks registered results 1 ns after the next rising edge. It compares each transfer against a model that still holds the values from before the transfer, and updates that model only afterwards. Pass-through outputs have no registers, so the bench checks them within the same half cycle in which it drives `dreq` or `hold_ack`.

// File: rtl/dma_seq_pkg.sv
// Shared types for the DMA channel sequencer.
package dma_seq_pkg;
    // Mode latched at load time.
    typedef struct packed {
        logic word;      // word channel
        logic auto_init; // reload at terminal count
        logic cascade;   // pass-through, no own transfers
    } xfer_mode_t;
endpackage

// File: rtl/dma_seq_ctr.sv
// Current/base address and count registers for one channel.
// Assumes: step is a one-cycle pulse per granted transfer; load wins over step.
module dma_seq_ctr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [AW-1:0] load_cnt,
    input  logic          step,
    input  logic          auto_init,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_cnt,
    output logic          at_tc
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] base_addr, base_cnt;

    assign at_tc = (cur_cnt == '0);

    // Load base and current values, then step or reload on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else if (load) begin
            base_addr <= load_addr;
            base_cnt  <= load_cnt;
            cur_addr  <= load_addr;
            cur_cnt   <= load_cnt;
        end else if (step) begin
            if (at_tc && auto_init) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end else begin
                cur_addr <= cur_addr + ONE;
                cur_cnt  <= cur_cnt - ONE;
            end
        end
    end

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !(at_tc && auto_init)) |=> (cur_addr == $past(cur_addr) + ONE));
    // R6
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && at_tc && !auto_init) |=> (cur_cnt == '1));
    // R9
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && at_tc && auto_init) |=> (cur_cnt == base_cnt && cur_addr == base_addr));
endmodule

// File: rtl/dma_seq_ctl.sv
// Handshake, mask and mode control for one channel.
// Assumes: at_tc reflects the count before the current transfer.
module dma_seq_ctl
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  xfer_mode_t load_mode,
    input  logic       dreq,
    input  logic       hold_ack,
    input  logic       at_tc,
    output xfer_mode_t mode_q,
    output logic       grant,
    output logic       dack,
    output logic       hold_req,
    output logic       tc,
    output logic       mask_q
);
    logic dack_q;

    assign grant    = !mask_q && !mode_q.cascade && dreq && !dack_q && !load;
    assign hold_req = mode_q.cascade && !mask_q && dreq;
    assign dack     = mode_q.cascade ? (hold_ack && !mask_q) : dack_q;

    // Latch mode on load.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= '0;
        else if (load) mode_q <= load_mode;
    end

    // Mask: set by reset and non-reloading terminal count, cleared by load.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  mask_q <= 1'b1;
        else if (load)                               mask_q <= 1'b0;
        else if (grant && at_tc && !mode_q.auto_init) mask_q <= 1'b1;
    end

    // Registered acknowledge and terminal-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dack_q <= 1'b0;
            tc     <= 1'b0;
        end else begin
            dack_q <= grant;
            tc     <= grant && at_tc;
        end
    end

    // R7
    dack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dack_q |=> !dack_q);
    // R6
    tc_with_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> dack);
    // R10
    masked_no_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && !load) |=> !dack_q);
    // R8
    tc_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && at_tc && !mode_q.auto_init) |=> mask_q);
    // R11
    cascade_no_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.cascade && !load) |=> !tc);
endmodule

// File: rtl/dma_seq_phys.sv
// Forms and registers the physical address for each granted transfer.
// Assumes: page is stable in the cycle a transfer is granted.
module dma_seq_phys #(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             word,
    input  logic [PW-1:0]    page,
    input  logic [AW-1:0]    cur_addr,
    output logic [AW+PW-1:0] mem_addr
);
    logic [AW+PW-1:0] byte_form, word_form;

    assign byte_form = {page, cur_addr};
    assign word_form = {page[PW-1:1], cur_addr, 1'b0};

    // Capture the address of the transfer being acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)       mem_addr <= '0;
        else if (capture) mem_addr <= word ? word_form : byte_form;
    end

    // R3
    word_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && word) |=> (mem_addr[0] == 1'b0));
    // R4
    page_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !word) |=> (mem_addr[AW+PW-1:AW] == $past(page)));
endmodule

// File: rtl/dma_xfer_seq.sv
// Top of the single-channel DMA address and count sequencer.
// Assumes: one channel, single-mode increment transfers, page held externally.
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [AW-1:0]    load_addr,
    input  logic [AW-1:0]    load_count,
    input  logic             load_word,
    input  logic             load_auto,
    input  logic             load_cascade,
    input  logic [PW-1:0]    page,
    input  logic             dreq,
    input  logic             hold_ack,
    output logic             dack,
    output logic             hold_req,
    output logic             tc,
    output logic [AW+PW-1:0] mem_addr,
    output logic [AW-1:0]    count_now,
    output logic             masked
);
    xfer_mode_t    load_mode, mode_q;
    logic          grant, at_tc;
    logic [AW-1:0] cur_addr;

    assign load_mode = '{word: load_word, auto_init: load_auto, cascade: load_cascade};

    dma_seq_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .load(load_stb), .load_mode(load_mode),
        .dreq(dreq), .hold_ack(hold_ack), .at_tc(at_tc), .mode_q(mode_q),
        .grant(grant), .dack(dack), .hold_req(hold_req), .tc(tc), .mask_q(masked)
    );

    dma_seq_ctr #(.AW(AW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(load_stb), .load_addr(load_addr),
        .load_cnt(load_count), .step(grant), .auto_init(mode_q.auto_init),
        .cur_addr(cur_addr), .cur_cnt(count_now), .at_tc(at_tc)
    );

    dma_seq_phys #(.AW(AW), .PW(PW)) u_phys (
        .clk(clk), .rst_n(rst_n), .capture(grant), .word(mode_q.word),
        .page(page), .cur_addr(cur_addr), .mem_addr(mem_addr)
    );

    // R11
    cascade_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.cascade && !load_stb) |=> $stable(count_now));
endmodule

// File: tb/dma_xfer_seq_test.sv
`timescale 1ns/1ps
module dma_xfer_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_stb = 1'b0;
    logic [15:0] load_addr = '0, load_count = '0;
    logic        load_word = 1'b0, load_auto = 1'b0, load_cascade = 1'b0;
    logic [7:0]  page = '0;
    logic        dreq = 1'b0, hold_ack = 1'b0;
    logic        dack, hold_req, tc, masked;
    logic [23:0] mem_addr;
    logic [15:0] count_now;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [15:0] m_addr, m_cnt, b_addr, b_cnt;
    logic        m_word, m_auto, m_casc, m_mask;

    always #2 clk = ~clk;

    dma_xfer_seq uut (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_addr(load_addr),
        .load_count(load_count), .load_word(load_word), .load_auto(load_auto),
        .load_cascade(load_cascade), .page(page), .dreq(dreq), .hold_ack(hold_ack),
        .dack(dack), .hold_req(hold_req), .tc(tc), .mem_addr(mem_addr),
        .count_now(count_now), .masked(masked)
    );

    function automatic logic [23:0] exp_phys(logic w, logic [7:0] pg, logic [15:0] a);
        return w ? {pg[7:1], a, 1'b0} : {pg, a};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(logic [15:0] a, logic [15:0] c, logic w, logic au, logic cs);
        @(negedge clk);
        load_stb = 1'b1; load_addr = a; load_count = c;
        load_word = w; load_auto = au; load_cascade = cs;
        @(negedge clk);
        load_stb = 1'b0;
        m_addr = a; m_cnt = c; b_addr = a; b_cnt = c;
        m_word = w; m_auto = au; m_casc = cs; m_mask = 1'b0;
        chk("R12 count_now", count_now, c);
        chk("R12 masked", masked, 0);
    endtask

    // One request/acknowledge exchange, checked against the model.
    task automatic xfer();
        logic active;
        active = !m_mask && !m_casc;
        @(negedge clk);
        dreq = 1'b1;
        @(posedge clk); #1;
        if (active) begin
            chk("R7 dack", dack, 1);
            chk("R2/R3 mem_addr", mem_addr, exp_phys(m_word, page, m_addr));
            chk("R5/R6 tc", tc, (m_cnt == 16'h0));
            if (m_cnt == 16'h0) begin
                if (m_auto) begin m_addr = b_addr; m_cnt = b_cnt; end
                else begin m_addr = m_addr + 1; m_cnt = 16'hFFFF; m_mask = 1'b1; end
            end else begin
                m_addr = m_addr + 1; m_cnt = m_cnt - 1;
            end
        end else begin
            chk("R8/R10 dack ignored", dack, 0);
            chk("R8 tc ignored", tc, 0);
        end
        @(negedge clk);
        dreq = 1'b0;
        chk("R4/R6 count_now", count_now, m_cnt);
        chk("R8/R9 masked", masked, m_mask);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h0D1A_5EED));
        dreq = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state with dreq high
        chk("R1 masked", masked, 1);
        chk("R1 dack", dack, 0);
        chk("R1 tc", tc, 0);
        chk("R1 hold_req", hold_req, 0);
        @(negedge clk);
        dreq = 1'b0;

        // R5: loaded 0 gives exactly one transfer with tc; R8 then ignored
        page = 8'h12;
        do_load(16'h1000, 16'h0000, 1'b0, 1'b0, 1'b0);
        xfer();
        xfer();
        chk("R8 masked after tc", masked, 1);

        // R4 byte wrap 0xFFFF -> 0x0000, page kept
        page = 8'h3C;
        do_load(16'hFFFF, 16'h0002, 1'b0, 1'b0, 1'b0);
        repeat (3) xfer();
        chk("R6 count after tc", count_now, 16'hFFFF);

        // R3 word wrap with odd page: bit 0 of page ignored
        page = 8'h3D;
        do_load(16'hFFFE, 16'h0002, 1'b1, 1'b0, 1'b0);
        repeat (4) xfer();

        // R9 autoinit: reload and stay unmasked
        page = 8'hA5;
        do_load(16'h0200, 16'h0001, 1'b0, 1'b1, 1'b0);
        repeat (5) xfer();
        chk("R9 masked stays 0", masked, 0);

        // R7 dreq held: alternate-cycle acknowledges
        do_load(16'h0040, 16'h0009, 1'b0, 1'b0, 1'b0);
        begin
            int acks = 0;
            @(negedge clk);
            dreq = 1'b1;
            for (int i = 0; i < 6; i++) begin
                @(posedge clk); #1;
                if (dack) acks++;
            end
            @(negedge clk);
            dreq = 1'b0;
            chk("R7 acks over 6 cycles", acks, 3);
            chk("R7 count after 3", count_now, 16'h0006);
        end

        // R12 request in load cycle not granted
        @(negedge clk);
        load_stb = 1'b1; load_addr = 16'h0777; load_count = 16'h0004;
        load_word = 1'b0; load_auto = 1'b0; load_cascade = 1'b0; dreq = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        load_stb = 1'b0; dreq = 1'b0;
        chk("R12 no grant on load", dack, 0);
        chk("R12 loaded count", count_now, 16'h0004);

        // R11 pass-through
        do_load(16'h0100, 16'h0003, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        dreq = 1'b1; #1;
        chk("R11 hold_req follows dreq", hold_req, 1);
        chk("R11 dack low without ack", dack, 0);
        hold_ack = 1'b1; #1;
        chk("R11 dack follows hold_ack", dack, 1);
        @(posedge clk); #1;
        chk("R11 tc stays low", tc, 0);
        @(negedge clk);
        dreq = 1'b0; hold_ack = 1'b0; #1;
        chk("R11 hold_req drops", hold_req, 0);
        chk("R11 count unchanged", count_now, 16'h0003);

        // Random configurations
        for (int k = 0; k < 40; k++) begin
            page = 8'($urandom);
            do_load(16'($urandom), 16'($urandom_range(0, 6)), 1'($urandom),
                    1'($urandom), 1'b0);
            for (int j = 0; j < 10; j++) xfer();
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule